// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block controls a port of 32 general-purpose pins through eight word-wide registers. Software sets direction, output level, pull resistors, drive strength and a combined slew/Schmitt attribute for each pin. It reads the pad levels back through a two-flop synchroniser. The block drives per-pin output-enable and output-value lines toward the pads, along with pull, drive, slow-slew and Schmitt-enable lines.

Two configuration bits change meaning with the pin's direction. The pull-down bit enables the pull-down on an input pin and selects open-drain on an output pin. The slew/Schmitt bit enables the Schmitt trigger on an input pin and selects slow slew on an output pin. In open-drain mode the pad is pulled low only while the output bit is zero and is released otherwise. A separate clear register lets software drop chosen output bits without a read-modify-write.

Writes take a word index, data and a strobe in one cycle. Reads are combinational on the same word index and have no side effects.

Top module: `gpio_port_regs`

## Requirements
- R1: The word index `addr_i` selects registers as follows: 0 direction, 1 pin input, 2 output, 3 output clear, 4 pull-up, 5 pull-down/open-drain, 6 drive, 7 slew/Schmitt. `rdata_o` shows the selected register in the same cycle, and a write with `wr_en_i` high lands on the next rising clock edge.
- R2: A direction bit of 1 makes the pin an output and 0 makes it an input. Direction resets to all zeros, and an input pin never has `pad_oe_o` set.
- R3: The pin input register is read-only, and a write to index 1 changes no register. It shows `pad_in_i` through two flops, so a pad change is still invisible after one rising edge and visible after the second. It resets to zero.
- R4: The output register resets to zero. Writing the clear register clears every output bit whose data bit is 1 and leaves the others unchanged. The clear register always reads as zero.
- R5: An output pin with its pull-down bit at 0 is push-pull: `pad_oe_o` is 1 and `pad_out_o` equals the output bit.
- R6: An output pin with its pull-down bit at 1 is open-drain: `pad_oe_o` equals the inverse of the output bit, and `pad_out_o` is 0.
- R7: `pad_pd_o` is set only for input pins whose pull-down bit is 1.
- R8: Pull-up resets to zero, and `pad_pu_o` follows the pull-up register in both directions.
- R9: Drive resets to zero (0 lower strength, 1 higher), and `pad_drv_o` follows the drive register.
- R10: Slew/Schmitt resets to all ones. The bit drives `pad_schmitt_o` on input pins and `pad_slow_o` on output pins, never both.
- R11: Reading any register, the pin input and clear registers included, changes no register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pad_in_i | input | 32 | Raw pad input levels |
| pad_oe_o | output | 32 | Pad output enable |
| pad_out_o | output | 32 | Pad output value |
| pad_pu_o | output | 32 | Pull-up enable |
| pad_pd_o | output | 32 | Pull-down enable |
| pad_drv_o | output | 32 | High drive strength select |
| pad_slow_o | output | 32 | Slow slew select (outputs) |
| pad_schmitt_o | output | 32 | Schmitt trigger enable (inputs) |

## Verification
The bench gives one port a mix of push-pull outputs, open-drain outputs with the output bit high and low, and inputs with and without pull-down. A design that ignored the dual meaning of the pull-down bit would drive open-drain pins high or leave pull-downs on output pins. It clears output bits and then reads the clear register back. A clear that acted as a plain store, or a clear register that kept its value, would show up here. It checks the synchroniser one cycle before and one cycle after the new pad value should appear, which catches an extra or a missing stage. It writes to the read-only index, and a design that stored that write would report corrupted state. Finally it resets again after the registers have been changed and checks that every reset value returns, the all-ones slew/Schmitt value included.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NUM_PINS = 32;
  localparam int unsigned REG_AW   = 3;

  typedef enum logic [REG_AW-1:0] {
    IDX_DIR  = 3'd0,
    IDX_PIN  = 3'd1,
    IDX_OUT  = 3'd2,
    IDX_CLR  = 3'd3,
    IDX_PU   = 3'd4,
    IDX_PD   = 3'd5,
    IDX_DRV  = 3'd6,
    IDX_SMT  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  pu_o,
  output logic [WIDTH-1:0]  pd_o,
  output logic [WIDTH-1:0]  drv_o,
  output logic [WIDTH-1:0]  smt_o
);
  logic [WIDTH-1:0] dir_q, out_q, pu_q, pd_q, drv_q, smt_q;
  logic wr_dir, wr_out, wr_clr, wr_pu, wr_pd, wr_drv, wr_smt;

  assign wr_dir = wr_en_i && (addr_i == IDX_DIR);
  assign wr_out = wr_en_i && (addr_i == IDX_OUT);
  assign wr_clr = wr_en_i && (addr_i == IDX_CLR);
  assign wr_pu  = wr_en_i && (addr_i == IDX_PU);
  assign wr_pd  = wr_en_i && (addr_i == IDX_PD);
  assign wr_drv = wr_en_i && (addr_i == IDX_DRV);
  assign wr_smt = wr_en_i && (addr_i == IDX_SMT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      drv_q <= '0;
      smt_q <= '1;
    end else begin
      if (wr_dir) dir_q <= wdata_i;
      if (wr_out) out_q <= wdata_i;
      else if (wr_clr) out_q <= out_q & ~wdata_i;
      if (wr_pu)  pu_q  <= wdata_i;
      if (wr_pd)  pd_q  <= wdata_i;
      if (wr_drv) drv_q <= wdata_i;
      if (wr_smt) smt_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      IDX_DIR: rdata_o = dir_q;
      IDX_PIN: rdata_o = pin_i;
      IDX_OUT: rdata_o = out_q;
      IDX_CLR: rdata_o = '0;
      IDX_PU:  rdata_o = pu_q;
      IDX_PD:  rdata_o = pd_q;
      IDX_DRV: rdata_o = drv_q;
      default: rdata_o = smt_q;
    endcase
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign pu_o  = pu_q;
  assign pd_o  = pd_q;
  assign drv_o = drv_q;
  assign smt_o = smt_q;

  AST_CLR_DROPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_CLR) |=> ((out_q & $past(wdata_i)) == '0)); // R4
  AST_CLR_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_CLR) |=> ((out_q & ~$past(wdata_i)) == ($past(out_q) & ~$past(wdata_i)))); // R4
  AST_PIN_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == IDX_PIN) |=> ($stable(dir_q) && $stable(out_q) && $stable(pu_q)
      && $stable(pd_q) && $stable(drv_q) && $stable(smt_q))); // R3
  AST_READ_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(dir_q) && $stable(out_q) && $stable(smt_q))); // R11
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] out_i,
  input  logic [WIDTH-1:0] pu_i,
  input  logic [WIDTH-1:0] pd_i,
  input  logic [WIDTH-1:0] drv_i,
  input  logic [WIDTH-1:0] smt_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic [WIDTH-1:0] pad_pd_o,
  output logic [WIDTH-1:0] pad_drv_o,
  output logic [WIDTH-1:0] pad_slow_o,
  output logic [WIDTH-1:0] pad_schmitt_o
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic is_out, open_drain;
    assign is_out     = dir_i[p];
    // pd bit: open-drain select on outputs, pull-down on inputs
    assign open_drain = is_out & pd_i[p];
    assign pad_oe_o[p]      = is_out & (open_drain ? ~out_i[p] : 1'b1);
    assign pad_out_o[p]     = is_out & ~open_drain & out_i[p];
    assign pad_pd_o[p]      = ~is_out & pd_i[p];
    assign pad_slow_o[p]    = is_out & smt_i[p];
    assign pad_schmitt_o[p] = ~is_out & smt_i[p];
  end

  assign pad_pu_o  = pu_i;
  assign pad_drv_o = drv_i;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = NUM_PINS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_pu_o,
  output logic [WIDTH-1:0]  pad_pd_o,
  output logic [WIDTH-1:0]  pad_drv_o,
  output logic [WIDTH-1:0]  pad_slow_o,
  output logic [WIDTH-1:0]  pad_schmitt_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_w, out_w, pu_w, pd_w, drv_w, smt_w;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  gpio_reg_file #(.WIDTH(WIDTH)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .pin_i  (pin_sync),
    .rdata_o(rdata_o),
    .dir_o  (dir_w),
    .out_o  (out_w),
    .pu_o   (pu_w),
    .pd_o   (pd_w),
    .drv_o  (drv_w),
    .smt_o  (smt_w)
  );

  gpio_pad_map #(.WIDTH(WIDTH)) i_pads (
    .dir_i        (dir_w),
    .out_i        (out_w),
    .pu_i         (pu_w),
    .pd_i         (pd_w),
    .drv_i        (drv_w),
    .smt_i        (smt_w),
    .pad_oe_o     (pad_oe_o),
    .pad_out_o    (pad_out_o),
    .pad_pu_o     (pad_pu_o),
    .pad_pd_o     (pad_pd_o),
    .pad_drv_o    (pad_drv_o),
    .pad_slow_o   (pad_slow_o),
    .pad_schmitt_o(pad_schmitt_o)
  );

  AST_INPUT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_w) == '0); // R2
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & dir_w & pd_w) == '0); // R6
  AST_OD_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir_w & pd_w & out_w) == '0); // R6
  AST_PD_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pd_o & dir_w) == '0); // R7
  AST_SLOW_SCHMITT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_slow_o & pad_schmitt_o) == '0); // R10
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [2:0]  waddr;
    logic [31:0] wdata;
    logic [2:0]  raddr;
    logic [31:0] rexp;
  } vec_t;

  // sequential: each row builds on the previous
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h0000_FFFF, 3'd0, 32'h0000_FFFF},
    '{3'd2, 32'hA5A5_5A5A, 3'd2, 32'hA5A5_5A5A},
    '{3'd3, 32'h0000_00FF, 3'd2, 32'hA5A5_5A00},
    '{3'd3, 32'hF000_0000, 3'd3, 32'h0000_0000},
    '{3'd1, 32'hFFFF_FFFF, 3'd1, 32'h0000_0000},
    '{3'd4, 32'h1234_5678, 3'd4, 32'h1234_5678},
    '{3'd5, 32'h0F0F_0F0F, 3'd5, 32'h0F0F_0F0F},
    '{3'd6, 32'h8000_0001, 3'd6, 32'h8000_0001},
    '{3'd7, 32'h00FF_00FF, 3'd7, 32'h00FF_00FF},
    '{3'd2, 32'hFFFF_FFFF, 3'd2, 32'hFFFF_FFFF}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, oe, pout, pu, pd, drv, slow, schm;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs i_gpio_port_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(oe), .pad_out_o(pout),
    .pad_pu_o(pu), .pad_pd_o(pd), .pad_drv_o(drv), .pad_slow_o(slow),
    .pad_schmitt_o(schm)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic reset_values(string tag);
    rd_check({tag, " R2 dir"}, 3'd0, 32'h0);
    rd_check({tag, " R3 pin"}, 3'd1, 32'h0);
    rd_check({tag, " R4 out"}, 3'd2, 32'h0);
    rd_check({tag, " R4 clr"}, 3'd3, 32'h0);
    rd_check({tag, " R8 pu"},  3'd4, 32'h0);
    rd_check({tag, " R7 pd"},  3'd5, 32'h0);
    rd_check({tag, " R9 drv"}, 3'd6, 32'h0);
    rd_check({tag, " R10 smt"}, 3'd7, 32'hFFFF_FFFF);
    check({tag, " R2 oe"}, oe, 32'h0);
    check({tag, " R10 schmitt"}, schm, 32'hFFFF_FFFF);
    check({tag, " R10 slow"}, slow, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_values("reset");
    rst_n = 1;
    @(negedge clk);
    reset_values("post-reset");

    // R1 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].waddr, VEC[i].wdata);
      rd_check($sformatf("R1 vec%0d", i), VEC[i].raddr, VEC[i].rexp);
    end

    // DIR=0000FFFF OUT=FFFFFFFF PD=0F0F0F0F SMT=00FF00FF
    check("R5/R6 oe all-high", oe, 32'h0000_F0F0);
    check("R5 pad_out", pout, 32'h0000_F0F0);
    check("R7 pad_pd", pd, 32'h0F0F_0000);
    check("R8 pad_pu", pu, 32'h1234_5678);
    check("R9 pad_drv", drv, 32'h8000_0001);
    check("R10 schmitt", schm, 32'h00FF_0000);
    check("R10 slow", slow, 32'h0000_00FF);

    // R6 open-drain pins 0..3 pulled low after clear
    wr(3'd3, 32'h0000_000F);
    rd_check("R4 partial clear", 3'd2, 32'hFFFF_FFF0);
    check("R6 od oe", oe, 32'h0000_F0FF);
    check("R6 od out low", pout, 32'h0000_F0F0);

    // R11 reads have no side effect
    addr = 3'd3; @(negedge clk);
    addr = 3'd1; @(negedge clk);
    rd_check("R11 out after reads", 3'd2, 32'hFFFF_FFF0);
    rd_check("R11 dir after reads", 3'd0, 32'h0000_FFFF);

    // R3 synchroniser depth
    addr = 3'd1;
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R3 pin after 1 edge", rdata, 32'h0);
    @(negedge clk);
    check("R3 pin after 2 edges", rdata, 32'hDEAD_BEEF);
    wr(3'd1, 32'h0);
    rd_check("R3 pin write ignored", 3'd1, 32'hDEAD_BEEF);
    rd_check("R3 out untouched", 3'd2, 32'hFFFF_FFF0);

    // R2 all inputs: nothing driven
    wr(3'd0, 32'h0);
    check("R2 inputs no oe", oe, 32'h0);
    check("R7 all pd on inputs", pd, 32'h0F0F_0F0F);

    // reset again
    pad_in = '0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    reset_values("re-reset");
    rst_n = 1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule